// File: doc/BRIEF.md
# Iterative Integer Divider with Remainder/Quotient Result Registers

This unit divides one W-bit integer by another, either as two's-complement or as unsigned numbers, and leaves the quotient in a `lo` result register and the remainder in a `hi` result register. The caller puts both operands and a mode select on the inputs and pulses `start` for one cycle. The operand mode applies to that operation only. Both modes use the same inputs and the same result registers.

An ordinary operation runs a restoring shift-subtract loop on the operand magnitudes. The loop produces one quotient bit per clock. Signs are then corrected in one final cycle. Two operand patterns bypass the loop and load fixed results in a single cycle: a zero divisor, and the most-negative dividend divided by all ones. Neither pattern traps or stalls. While an operation is in flight, `busy` is high and any further `start` is dropped. Completion is marked by a one-cycle `done`. After that, the results stay in place until the next operation completes.

Top module: `hilo_divider`

## Requirements
- R1: While `rst` is high at a clock edge, `hi`, `lo`, `busy` and `done` become 0 after that edge.
- R2: With `is_signed`=0 and a nonzero divisor (other than the R7 pattern), `lo` = floor(dividend/divisor) and `hi` = dividend mod divisor, both taken as unsigned W-bit values.
- R3: With `is_signed`=1 and a nonzero divisor (other than the R6 pattern), the quotient is truncated toward zero. The remainder carries the sign of the dividend, and quotient*divisor+remainder = dividend.
- R4: With `is_signed`=1 and divisor 0, `hi` = dividend. `lo` = 1 when dividend bit W-1 is set, and all ones otherwise.
- R5: With `is_signed`=0 and divisor 0, `lo` = all ones and `hi` = dividend.
- R6: With `is_signed`=1, dividend = only bit W-1 set and divisor = all ones, `lo` = only bit W-1 set and `hi` = 0.
- R7: With `is_signed`=0, dividend = only bit W-1 set and divisor = all ones, `lo` = 0 and `hi` = only bit W-1 set.
- R8: The R4–R7 cases finish without iterating. Counting the edge that samples `start` as edge 0, `done` is high after edge 0 and `busy` stays low throughout.
- R9: Every other operation raises `busy` after edge 0. `busy` stays high until edge W+1, which writes the results, raises `done` and clears `busy`. `busy` and `done` are never high together.
- R10: `done` is high for exactly one cycle per completed operation.
- R11: A `start` while `busy` is high is ignored. The running operation's results and its completion edge are unchanged.
- R12: `hi` and `lo` change only on the edge that raises `done`. Otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a division |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | W | Numerator, sampled with `start` |
| divisor | input | W | Denominator, sampled with `start` |
| hi | output | W | Remainder register |
| lo | output | W | Quotient register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A faulty iteration count or a stuck step in the loop makes `done` arrive on a different edge than W+1. It can also leave wrong low-order quotient bits, which show in `lo` on the completion edge itself. A sign flag latched wrongly at start stays hidden until the final correction cycle. It then appears only for mixed-sign or negative-dividend operands, so those must be run to observe it. A special-case detector that misfires shows up one cycle after `start`, through `busy` rising when it should not or `done` failing to appear.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_special.sv
// Recognises operands whose result is fixed and supplies that result.
module div_special #(
  parameter int W = 32
) (
  input  logic         is_signed,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         hit,
  output logic [W-1:0] sp_hi,
  output logic [W-1:0] sp_lo
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONE = {W{1'b1}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic by_zero;
  logic edge_pair;

  always_comb begin
    by_zero   = (den == '0);
    edge_pair = (num == MIN_NEG) && (den == ALL_ONE);
    hit       = by_zero || edge_pair;
    sp_hi     = '0;
    sp_lo     = '0;
    if (by_zero) begin
      sp_hi = num;
      sp_lo = (is_signed && num[W-1]) ? ONE : ALL_ONE;
    end else if (edge_pair) begin
      sp_hi = is_signed ? '0 : MIN_NEG;
      sp_lo = is_signed ? MIN_NEG : '0;
    end
  end
endmodule

// File: rtl/div_core.sv
// Restoring unsigned divider, one quotient bit per step.
module div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] num_mag,
  input  logic [W-1:0] den_mag,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  logic [W-1:0]  den_q;
  logic [CW-1:0] cnt;
  logic [W:0]    part;
  logic [W:0]    diff;

  always_comb begin
    part = {rem, quo[W-1]};
    diff = part - {1'b0, den_q};
    last = step && (cnt == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo   <= '0;
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
    end else if (load) begin
      quo   <= num_mag;
      rem   <= '0;
      den_q <= den_mag;
      cnt   <= '0;
    end else if (step) begin
      if (!diff[W]) begin
        rem <= diff[W-1:0];
        quo <= {quo[W-2:0], 1'b1};
      end else begin
        rem <= part[W-1:0];
        quo <= {quo[W-2:0], 1'b0};
      end
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/div_fixup.sv
// Applies sign correction to the magnitude results.
module div_fixup #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  logic         neg_quo,
  input  logic         neg_rem,
  output logic [W-1:0] quo_out,
  output logic [W-1:0] rem_out
);
  always_comb begin
    quo_out = neg_quo ? (~quo_mag + 1'b1) : quo_mag;
    rem_out = neg_rem ? (~rem_mag + 1'b1) : rem_mag;
  end
endmodule

// File: rtl/hilo_divider.sv
module hilo_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic         busy,
  output logic         done
);
  import div_pkg::*;

  div_state_e   state;
  logic         accept;
  logic         sp_hit;
  logic [W-1:0] sp_hi;
  logic [W-1:0] sp_lo;
  logic         num_neg;
  logic         den_neg;
  logic [W-1:0] num_mag;
  logic [W-1:0] den_mag;
  logic         neg_quo_q;
  logic         neg_rem_q;
  logic [W-1:0] core_quo;
  logic [W-1:0] core_rem;
  logic         core_last;
  logic [W-1:0] fix_quo;
  logic [W-1:0] fix_rem;

  always_comb begin
    accept  = start && (state == ST_IDLE);
    num_neg = is_signed && dividend[W-1];
    den_neg = is_signed && divisor[W-1];
    num_mag = num_neg ? (~dividend + 1'b1) : dividend;
    den_mag = den_neg ? (~divisor + 1'b1) : divisor;
  end

  div_special #(.W(W)) u_special (
    .is_signed (is_signed),
    .num       (dividend),
    .den       (divisor),
    .hit       (sp_hit),
    .sp_hi     (sp_hi),
    .sp_lo     (sp_lo)
  );

  div_core #(.W(W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .load    (accept && !sp_hit),
    .step    (state == ST_RUN),
    .num_mag (num_mag),
    .den_mag (den_mag),
    .quo     (core_quo),
    .rem     (core_rem),
    .last    (core_last)
  );

  div_fixup #(.W(W)) u_fixup (
    .quo_mag (core_quo),
    .rem_mag (core_rem),
    .neg_quo (neg_quo_q),
    .neg_rem (neg_rem_q),
    .quo_out (fix_quo),
    .rem_out (fix_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hi        <= '0;
      lo        <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (sp_hit) begin
              hi   <= sp_hi;
              lo   <= sp_lo;
              done <= 1'b1;
            end else begin
              neg_quo_q <= num_neg ^ den_neg;
              neg_rem_q <= num_neg;
              busy      <= 1'b1;
              state     <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (core_last) state <= ST_FIN;
        end
        ST_FIN: begin
          hi    <= fix_rem;
          lo    <= fix_quo;
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hilo_divider_chk.sv
module hilo_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         is_signed,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo,
  input logic         busy,
  input logic         done
);
  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_results_R12: assert property (@(posedge clk) disable iff (rst)
    (!$stable(hi) || !$stable(lo)) |-> done);

  assert_zero_hi_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=> (done && hi == $past(dividend)));

  assert_zero_unsigned_lo_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !is_signed && divisor == '0) |=> (lo == {W{1'b1}}));

  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_special_no_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=> !busy);
endmodule

bind hilo_divider hilo_divider_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .is_signed (is_signed),
  .dividend  (dividend),
  .divisor   (divisor),
  .hi        (hi),
  .lo        (lo),
  .busy      (busy),
  .done      (done)
);

// File: tb/tb_hilo_divider.sv
`timescale 1ns/1ps
module tb_hilo_divider;
  localparam int W = 32;
  localparam logic [W-1:0] MINV = 32'h8000_0000;
  localparam logic [W-1:0] ONES = 32'hFFFF_FFFF;
  localparam int NV = 16;
  // {is_signed, dividend, divisor}
  localparam logic [2*W:0] VEC [NV] = '{
    {1'b0, 32'd100,        32'd7},
    {1'b0, 32'hFFFF_FFFF,  32'd1},
    {1'b0, 32'd5,          32'd10},
    {1'b0, 32'hFFFF_FFFF,  32'hFFFF_FFFF},
    {1'b0, 32'hDEAD_BEEF,  32'h0001_2345},
    {1'b1, 32'hFFFF_FFF9,  32'd2},
    {1'b1, 32'd7,          32'hFFFF_FFFE},
    {1'b1, 32'hFFFF_FFF9,  32'hFFFF_FFFE},
    {1'b1, 32'h8000_0000,  32'd2},
    {1'b1, 32'd0,          32'd5},
    {1'b1, 32'h8000_0000,  32'hFFFF_FFFF},
    {1'b0, 32'h8000_0000,  32'hFFFF_FFFF},
    {1'b1, 32'hFFFF_FFFB,  32'd0},
    {1'b1, 32'd5,          32'd0},
    {1'b0, 32'h1234_5678,  32'd0},
    {1'b1, 32'h8000_0000,  32'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic is_signed = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] hi, lo;
  logic busy, done;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  hilo_divider #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor),
    .hi(hi), .lo(lo), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected results computed from the requirements.
  function automatic void ref_div(input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                                  output logic [W-1:0] eh, output logic [W-1:0] el,
                                  output logic special, output string req);
    special = 1'b1;
    if (b == '0) begin
      eh = a;
      el = (s && a[W-1]) ? 32'd1 : ONES;
      req = s ? "R4" : "R5";
    end else if (a == MINV && b == ONES) begin
      eh = s ? '0 : MINV;
      el = s ? MINV : '0;
      req = s ? "R6" : "R7";
    end else begin
      special = 1'b0;
      if (s) begin
        el = $signed(a) / $signed(b);
        eh = $signed(a) % $signed(b);
        req = "R3";
      end else begin
        el = a / b;
        eh = a % b;
        req = "R2";
      end
    end
  endfunction

  // Issues one operation; returns the cycle count until done and busy seen in cycle 1.
  task automatic run_op(input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit extra_start, output int k, output logic busy1);
    @(negedge clk);
    is_signed = s; dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    busy1 = busy;
    while (!done && k < 80) begin
      if (extra_start && k == 5) begin
        is_signed = 1'b1; dividend = 32'd1000; divisor = 32'd3; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] eh, el, h0, l0;
    logic sp, b1;
    string rq;
    int k;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hi", hi, '0);
    check("R1 lo", lo, '0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      ref_div(VEC[i][2*W], VEC[i][2*W-1:W], VEC[i][W-1:0], eh, el, sp, rq);
      run_op(VEC[i][2*W], VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b0, k, b1);
      check({rq, " lo"}, lo, el);
      check({rq, " hi"}, hi, eh);
      check("R9 busy low at done", {31'd0, busy}, 32'd0);
      if (sp) begin
        check("R8 latency", k, 1);
        check("R8 busy stays low", {31'd0, b1}, 32'd0);
      end else begin
        check("R9 latency", k, W + 2);
        check("R9 busy after start", {31'd0, b1}, 32'd1);
      end
    end

    // R10 and R12: done drops, results hold
    h0 = hi; l0 = lo;
    @(negedge clk);
    check("R10 done single", {31'd0, done}, 32'd0);
    repeat (4) @(negedge clk);
    check("R12 hi hold", hi, h0);
    check("R12 lo hold", lo, l0);

    // R11: start while busy is ignored
    run_op(1'b0, 32'd1000, 32'd7, 1'b1, k, b1);
    check("R11 lo", lo, 32'd142);
    check("R11 hi", hi, 32'd6);
    check("R11 latency", k, W + 2);
    repeat (3) @(negedge clk);
    check("R11 no second op", {31'd0, busy}, 32'd0);
    check("R11 hold hi", hi, 32'd6);

    // R1: reset mid-operation clears everything
    @(negedge clk);
    is_signed = 1'b0; dividend = 32'd50; divisor = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", {31'd0, busy}, 32'd0);
    check("R1 lo after reset", lo, '0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule